// File: doc/BRIEF.md
# Pulse-Swallow Loop Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It takes a divide code N and a band select. Each period of the selected oscillator input reaches it as a one-cycle strobe, and the block emits one output pulse to the phase comparator every N+1 oscillator periods. The block runs on the fast clock, and the strobe marks where each input period ends.

In the high band the input strobes come from an external dual-modulus prescaler that divides by 64 or by 65. The block drives that prescaler's modulus line using pulse-swallow counting. The value N+1 is split into a main count M and a swallow count A. The modulus line asks for division by 65 during the first A prescaler periods of each output cycle and by 64 for the rest. In the low band the strobes come straight from the low-band input. The block counts them directly and keeps the modulus line idle. A new code or band is picked up only when the current output cycle ends.

Top module: `swallow_div`

## Requirements
- R1: While reset is high, and directly after it, `pulse_out` and `mod_hi` are low. The first `in_tick` after reset is a terminal count: it produces a pulse and loads the code and band present at that moment.
- R2: With `band_fm`=0 latched, `pulse_out` goes high once every N+1 `in_tick` strobes. It is high for exactly the one clock after the clock edge that consumed the terminal strobe.
- R3: During an output cycle that runs with `band_fm`=0 latched, `mod_hi` stays low.
- R4: With `band_fm`=1 latched, let M = (N+1) >> 6 and A = (N+1) mod 64. `pulse_out` goes high once every M strobes. Codes are valid in this band when M >= A and M >= 1.
- R5: With `band_fm`=1 latched, `mod_hi`=1 (divide by 65) holds from the terminal count until A further strobes have been consumed, and it is 0 (divide by 64) after that. With a 64/65 prescaler, one output cycle therefore spans exactly N+1 oscillator cycles.
- R6: A change of `div_code` in the middle of an output cycle does not alter that cycle. It takes effect at the next terminal count.
- R7: A change of `band_fm` in the middle of an output cycle takes effect only at the next terminal count, for both the counting mode and the modulus line.
- R8: The counters advance only on clocks where `in_tick` is high, so the cycle count of an output period scales with the spacing of the strobes.
- R9: `pulse_out` is never high unless `in_tick` was high at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| band_fm | input | 1 | Band select: 1 = high band with prescaler, 0 = low band counted directly |
| div_code | input | 13 | Divide code N; the division ratio is N+1 |
| in_tick | input | 1 | One-cycle strobe marking the end of one period of the selected input |
| mod_hi | output | 1 | Modulus control to the prescaler: 1 = divide by 65, 0 = divide by 64 |
| pulse_out | output | 1 | One-cycle pulse at each terminal count, sent to the phase comparator |

## Verification
The divider is driven by a model of the input stage: a 64/65 prescaler that obeys `mod_hi` in the high band, and a fixed-spacing strobe source in the low band. Each output period is checked for both its strobe count and its fast-clock length. In the low band, spacings of 1, 2, 3 and 4 clocks show that counting follows only the strobes. High-band codes with A=0, A=5, A=M=63, and the largest code (where N+1 carries into a fourteenth bit) each give a different mix of 65 and 64 periods, so a wrong swallow count shows up as an exact cycle mismatch. Each new code and each band change is applied in mid-cycle, so a period that picked up new settings too early is seen in both its strobe and its cycle count.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int DEF_CODE_W  = 13;
    localparam int DEF_PS_LOG2 = 6;

    typedef enum logic {
        BAND_AM = 1'b0,
        BAND_FM = 1'b1
    } band_e;

endpackage

// File: rtl/swd_load_calc.sv
module swd_load_calc
    import swd_pkg::*;
#(
    parameter int CODE_W  = DEF_CODE_W,
    parameter int PS_LOG2 = DEF_PS_LOG2
) (
    input  logic [CODE_W-1:0]  code,
    input  band_e              band,
    output logic [CODE_W-1:0]  main_ld,
    output logic [PS_LOG2-1:0] swal_ld
);
    localparam int SUM_W  = CODE_W + 1;
    localparam int MAIN_W = SUM_W - PS_LOG2;

    logic [SUM_W-1:0]  ratio;
    logic [MAIN_W-1:0] main_full;

    always_comb begin
        ratio     = {1'b0, code} + SUM_W'(1);
        main_full = ratio[SUM_W-1:PS_LOG2];
        if (band == BAND_FM) begin
            // main counter runs M periods; terminal at zero, so load M-1
            main_ld = (main_full == '0) ? '0 : CODE_W'(main_full - MAIN_W'(1));
            swal_ld = ratio[PS_LOG2-1:0];
        end else begin
            // direct count: N down to zero is N+1 strobes
            main_ld = code;
            swal_ld = '0;
        end
    end
endmodule

// File: rtl/swd_main_cnt.sv
module swd_main_cnt
    import swd_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_tick,
    input  logic [CODE_W-1:0] load_val,
    output logic              term
);
    logic [CODE_W-1:0] cnt;

    assign term = in_tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (term) begin
            cnt <= load_val;
        end else if (in_tick) begin
            cnt <= cnt - CODE_W'(1);
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !in_tick |=> $stable(cnt)); // R8
endmodule

// File: rtl/swd_swallow.sv
module swd_swallow
    import swd_pkg::*;
#(
    parameter int PS_LOG2 = DEF_PS_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_tick,
    input  logic               term,
    input  logic [PS_LOG2-1:0] swal_ld,
    input  band_e              band_ld,
    output logic               mod_hi
);
    logic [PS_LOG2-1:0] swal_cnt;
    band_e              band_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            swal_cnt <= '0;
            band_q   <= BAND_AM;
        end else if (term) begin
            swal_cnt <= swal_ld;
            band_q   <= band_ld;
        end else if (in_tick && (swal_cnt != '0)) begin
            swal_cnt <= swal_cnt - PS_LOG2'(1);
        end
    end

    assign mod_hi = (band_q == BAND_FM) && (swal_cnt != '0);

    AST_MOD_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_hi) |-> $past(in_tick)); // R5
    AST_MOD_RISE_ON_TERM: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_hi) |-> $past(term)); // R7
endmodule

// File: rtl/swallow_div.sv
module swallow_div
    import swd_pkg::*;
#(
    parameter int CODE_W  = DEF_CODE_W,
    parameter int PS_LOG2 = DEF_PS_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              band_fm,
    input  logic [CODE_W-1:0] div_code,
    input  logic              in_tick,
    output logic              mod_hi,
    output logic              pulse_out
);
    logic [CODE_W-1:0]  main_ld;
    logic [PS_LOG2-1:0] swal_ld;
    logic               term;
    band_e              band_in;

    assign band_in = band_e'(band_fm);

    swd_load_calc #(.CODE_W(CODE_W), .PS_LOG2(PS_LOG2)) calc_i (
        .code    (div_code),
        .band    (band_in),
        .main_ld (main_ld),
        .swal_ld (swal_ld)
    );

    swd_main_cnt #(.CODE_W(CODE_W)) main_i (
        .clk      (clk),
        .rst      (rst),
        .in_tick  (in_tick),
        .load_val (main_ld),
        .term     (term)
    );

    swd_swallow #(.PS_LOG2(PS_LOG2)) swal_i (
        .clk     (clk),
        .rst     (rst),
        .in_tick (in_tick),
        .term    (term),
        .swal_ld (swal_ld),
        .band_ld (band_in),
        .mod_hi  (mod_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_out <= 1'b0;
        end else begin
            pulse_out <= term;
        end
    end

    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> $past(in_tick)); // R9
    AST_AM_NO_MOD: assert property (@(posedge clk) disable iff (rst)
        (pulse_out && !$past(band_fm)) |-> !mod_hi); // R3
    AST_FM_SWALLOW_START: assert property (@(posedge clk) disable iff (rst)
        (pulse_out && $past(band_fm)
         && ((($past(div_code) + CODE_W'(1)) & CODE_W'((1 << PS_LOG2) - 1)) != '0))
        |-> mod_hi); // R5
endmodule

// File: tb/swallow_div_tb_top.sv
`timescale 1ns/1ps
module swallow_div_tb_top;

    typedef struct {
        int    ticks;
        int    cycles;
        bit    fm;
        int    gap;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        band_fm = 1'b0;
    logic [12:0] div_code = 13'd9;
    logic        in_tick = 1'b0;
    logic        mod_hi;
    logic        pulse_out;

    int   total = 0;
    int   bad = 0;
    exp_t q[$];
    bit   src_fm = 1'b0;
    int   src_gap = 3;
    bit   cur_fm = 1'b0;
    bit   last_fm = 1'b0;

    always #4 clk = ~clk;

    swallow_div dut_i (
        .clk       (clk),
        .rst       (rst),
        .band_fm   (band_fm),
        .div_code  (div_code),
        .in_tick   (in_tick),
        .mod_hi    (mod_hi),
        .pulse_out (pulse_out)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // input stage model: 64/65 prescaler in high band, fixed spacing in low band
    initial begin
        bit pend = 1'b1;
        int remain = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                in_tick = 1'b0;
                pend = 1'b1;
            end else begin
                if (pend) begin
                    remain = src_fm ? (mod_hi ? 65 : 64) : src_gap;
                    pend = 1'b0;
                end
                remain--;
                if (remain == 0) begin
                    in_tick = 1'b1;
                    pend = 1'b1;
                end else begin
                    in_tick = 1'b0;
                end
            end
        end
    end

    // monitor: measures each output period and compares with the queue
    initial begin
        int   tk = 0;
        int   cyc = 0;
        bit   modbad = 1'b0;
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (rst) begin
                tk = 0; cyc = 0; modbad = 1'b0;
                continue;
            end
            cyc++;
            if (in_tick) tk++;
            if (pulse_out) begin
                chk(in_tick === 1'b1, "R9", int'(in_tick), 1);
                if (q.size() > 0) begin
                    e = q.pop_front();
                    chk(tk == e.ticks, e.req, tk, e.ticks);
                    if (e.cycles != 0)
                        chk(cyc == e.cycles, e.fm ? "R5" : "R8", cyc, e.cycles);
                    if (!e.fm)
                        chk(!modbad, "R3", int'(modbad), 0);
                    if (q.size() > 0) begin
                        src_fm = q[0].fm;
                        src_gap = q[0].gap;
                        cur_fm = q[0].fm;
                    end
                end
                tk = 0; cyc = 0; modbad = 1'b0;
            end
            if (!cur_fm && mod_hi) modbad = 1'b1;
        end
    end

    // driver: applies a code/band mid-cycle and queues the periods it expects
    task automatic segment(int code, bit fm, int gap, int n, string req);
        exp_t  e;
        int    np1 = code + 1;
        string first_req;
        wait (q.size() <= 1);
        @(negedge clk);
        first_req = (fm != last_fm) ? "R7" : "R6";
        div_code = code[12:0];
        band_fm = fm;
        for (int i = 0; i < n; i++) begin
            e.ticks  = fm ? (np1 >> 6) : np1;
            e.cycles = fm ? np1 : np1 * gap;
            e.fm     = fm;
            e.gap    = gap;
            e.req    = (i == 0) ? first_req : req;
            q.push_back(e);
        end
        last_fm = fm;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired, pending=%0d expected=0", q.size());
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t e0;
        e0.ticks = 1; e0.cycles = 0; e0.fm = 1'b0; e0.gap = 3; e0.req = "R1";
        q.push_back(e0);
        repeat (5) @(posedge clk);
        #1;
        chk(pulse_out === 1'b0, "R1", int'(pulse_out), 0);
        chk(mod_hi === 1'b0, "R1", int'(mod_hi), 0);
        @(negedge clk);
        rst = 1'b0;
        chk(pulse_out === 1'b0, "R1", int'(pulse_out), 0);
        chk(mod_hi === 1'b0, "R1", int'(mod_hi), 0);

        segment(9,    1'b0, 3, 3, "R2");
        segment(0,    1'b0, 2, 4, "R2");
        segment(4484, 1'b1, 1, 3, "R4");
        segment(5119, 1'b1, 1, 2, "R4");
        segment(4094, 1'b1, 1, 2, "R5");
        segment(8191, 1'b1, 1, 2, "R4");
        segment(8191, 1'b0, 1, 2, "R2");
        segment(5,    1'b0, 4, 3, "R8");
        wait (q.size() == 0);
        repeat (10) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule